// File: doc/BRIEF.md
# Five-Port Controller Multitap Sequencer

This block sits on the expander side of a game controller multitap. A host reads up to five four-wire controllers through one port. It does so by pulsing a clear line and then toggling a select line. The sequencer watches the host's clear and select lines. It steers a private clear/select pair to each downstream port, one port at a time, and routes that port's 4-bit data nibble back to the host.

A rising edge on host clear restarts the walk at port 1. While clear stays high, select toggles reach port 1 only and do not move the walk. Once clear is low, every select edge counts, whether rising or falling. Each port is held for one low phase and one high phase of select, and the ports are visited in order 1 to 5. After the tenth counted edge, every port is released and the host reads zero. It keeps reading zero until the next clear.

The host lines are asynchronous to the block. They pass through a synchronizer into the system clock before any edge is detected.

Top module: `multitap_seq`

## Requirements
- R1: While rstN is low, and after reset until the first rising edge of host clear, no port is active: every bit of portClr and portSel is 1 and hostData is 0000.
- R2: A rising edge on hostClr makes port 1 active: portClr bit 0 is 0, all other portClr bits are 1, and hostData carries port 1's nibble.
- R3: While hostClr stays high, edges on hostSel do not move the walk off port 1. Port 1's select output (portSel bit 0) still follows hostSel.
- R4: With hostClr low, every hostSel edge in either direction advances a count of edges since the last restart. Port k (k = 1..5) is active for counts 2k-2 and 2k-1.
- R5: The active port has its portClr bit at 0 and its portSel bit equal to the synchronized hostSel. Every inactive port has both its portClr and portSel bits at 1.
- R6: hostData equals the active port's nibble. Port k's nibble sits at portData bits [4k-1:4k-4], so port 1 is in bits [3:0].
- R7: Once ten edges have been counted, no port is active and hostData is 0000. This holds whatever portData carries. Further hostSel edges leave the block in this state and never wrap back to port 1.
- R8: A new rising edge on hostClr at any point in the walk, including after R7's terminal state, restarts the walk at port 1 with a count of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostClr | input | 1 | Host clear line, asynchronous |
| hostSel | input | 1 | Host select line, asynchronous |
| portData | input | NUM_PORTS*NIB_W | Data nibbles of all ports, port 1 in the low bits |
| portClr | output | NUM_PORTS | Per-port clear outputs, low on the active port |
| portSel | output | NUM_PORTS | Per-port select outputs, follows host select on the active port |
| hostData | output | NIB_W | Nibble returned to the host |

## Verification
A change on hostClr or hostSel takes two clock edges to pass the synchronizer. By then the active port's select output already shows the new level. The edge count, and with it the choice of port, clear outputs and data mux, moves on the third edge after the input changes. The bench drives each input change at a falling clock edge. It then waits five full cycles and samples at a falling edge, so every result is sampled after its register has settled. Changes on portData reach hostData with no clock delay, and the bench checks them after the same wait.

// File: rtl/mtap_pkg.sv
package mtap_pkg;

  // Strobes from control to datapath, valid for one clock each.
  typedef struct packed {
    logic restart;  // synchronized clear rose: go back to port 1
    logic advance;  // counted select edge (clear low)
  } seqStrobe_t;

endpackage

// File: rtl/mtap_ctrl.sv
module mtap_ctrl
  import mtap_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostClr,
  input  logic       hostSel,
  output seqStrobe_t strobe,
  output logic       selSync
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [LAST:0] clrChain;
  logic [LAST:0] selChain;
  logic          clrSync;
  logic          clrPrev;
  logic          selPrev;

  // Synchronizer stages; idle levels are clear low, select high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clrChain <= '0;
      selChain <= '1;
      clrPrev  <= 1'b0;
      selPrev  <= 1'b1;
    end else begin
      clrChain <= {clrChain[LAST-1:0], hostClr};
      selChain <= {selChain[LAST-1:0], hostSel};
      clrPrev  <= clrSync;
      selPrev  <= selSync;
    end
  end

  assign clrSync = clrChain[LAST];
  assign selSync = selChain[LAST];

  always_comb begin
    strobe.restart = clrSync & ~clrPrev;
    // Select edges are frozen out while clear is held high (R3).
    strobe.advance = (selSync ^ selPrev) & ~clrSync;
  end

  // R8: a restart is a single-cycle event per clear pulse.
  a_r8_restart_single: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> !strobe.restart);

  // R3: a clear edge and a counted select edge never coincide.
  a_r3_no_joint_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.restart && strobe.advance));

endmodule

// File: rtl/mtap_dpath.sv
module mtap_dpath
  import mtap_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned NIB_W     = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seqStrobe_t                 strobe,
  input  logic                       selSync,
  input  logic [NUM_PORTS*NIB_W-1:0] portData,
  output logic [NUM_PORTS-1:0]       portClr,
  output logic [NUM_PORTS-1:0]       portSel,
  output logic [NIB_W-1:0]           hostData
);

  localparam int unsigned EDGE_LIMIT = 2 * NUM_PORTS;
  localparam int unsigned CNT_W      = $clog2(EDGE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(EDGE_LIMIT);

  logic [CNT_W-1:0]     edgeCnt;
  logic [CNT_W-1:0]     pairIdx;
  logic                 anyActive;
  logic [NUM_PORTS-1:0] isActive;

  // Edge count, saturating at the terminal value; reset parks it there.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= LIMIT_V;
    end else if (strobe.restart) begin
      edgeCnt <= '0;
    end else if (strobe.advance && (edgeCnt != LIMIT_V)) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  assign pairIdx   = edgeCnt >> 1;
  assign anyActive = (edgeCnt < LIMIT_V);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gPort
    assign isActive[g] = anyActive && (pairIdx == CNT_W'(g));
    assign portClr[g]  = ~isActive[g];
    assign portSel[g]  = isActive[g] ? selSync : 1'b1;
  end

  always_comb begin
    hostData = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (isActive[i]) hostData = hostData | portData[i*NIB_W +: NIB_W];
    end
  end

  // R2 / R8: a restart lands on port 1.
  a_r2_restart_port1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (portClr[0] == 1'b0));

  // R3: with no strobe the walk does not move.
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restart && !strobe.advance) |=> $stable(edgeCnt));

  // R4: one counted edge adds exactly one.
  a_r4_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.restart && edgeCnt < LIMIT_V)
      |=> edgeCnt == $past(edgeCnt) + 1'b1);

  // R5: at most one port has its clear low.
  a_r5_one_port: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~portClr));

  // R7: terminal state never wraps without a restart.
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt == LIMIT_V && !strobe.restart) |=> edgeCnt == LIMIT_V);

  // R7: nothing active means a zero nibble.
  a_r7_zero_nibble: assert property (@(posedge clk) disable iff (!rstN)
    (&portClr) |-> (hostData == '0));

endmodule

// File: rtl/multitap_seq.sv
module multitap_seq
  import mtap_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 5,
  parameter int unsigned NIB_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostClr,
  input  logic                       hostSel,
  input  logic [NUM_PORTS*NIB_W-1:0] portData,
  output logic [NUM_PORTS-1:0]       portClr,
  output logic [NUM_PORTS-1:0]       portSel,
  output logic [NIB_W-1:0]           hostData
);

  seqStrobe_t strobe;
  logic       selSync;

  mtap_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostClr (hostClr),
    .hostSel (hostSel),
    .strobe  (strobe),
    .selSync (selSync)
  );

  mtap_dpath #(.NUM_PORTS(NUM_PORTS), .NIB_W(NIB_W)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .selSync  (selSync),
    .portData (portData),
    .portClr  (portClr),
    .portSel  (portSel),
    .hostData (hostData)
  );

endmodule

// File: tb/tb_multitap_seq.sv
`timescale 1ns/1ps
module tb_multitap_seq;

  localparam int NP   = 5;
  localparam int NW   = 4;
  localparam int WAIT = 5;

  typedef struct packed { logic sel; logic [2:0] port; } vec_t;

  // Select level driven per step and the port expected afterwards (0 = none).
  localparam vec_t VECS [12] = '{
    '{1'b0, 3'd1}, '{1'b1, 3'd2}, '{1'b0, 3'd2}, '{1'b1, 3'd3},
    '{1'b0, 3'd3}, '{1'b1, 3'd4}, '{1'b0, 3'd4}, '{1'b1, 3'd5},
    '{1'b0, 3'd5}, '{1'b1, 3'd0}, '{1'b0, 3'd0}, '{1'b1, 3'd0}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             hostClr = 1'b0;
  logic             hostSel = 1'b1;
  logic [NP*NW-1:0] portData;
  logic [NP-1:0]    portClr;
  logic [NP-1:0]    portSel;
  logic [NW-1:0]    hostData;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  multitap_seq dut (
    .clk(clk), .rstN(rstN), .hostClr(hostClr), .hostSel(hostSel),
    .portData(portData), .portClr(portClr), .portSel(portSel),
    .hostData(hostData)
  );

  task automatic settle();
    repeat (WAIT) @(negedge clk);
  endtask

  task automatic checkPort(string tag, int expPort, logic selLvl);
    logic [NP-1:0] eClr = '1;
    logic [NP-1:0] eSel = '1;
    logic [NW-1:0] eDat = '0;
    if (expPort > 0) begin
      eClr[expPort-1] = 1'b0;
      eSel[expPort-1] = selLvl;
      eDat = portData[(expPort-1)*NW +: NW];
    end
    checks += 3;
    if (portClr !== eClr) begin
      errors++;
      $display("FAIL %s portClr actual=%b expected=%b", tag, portClr, eClr);
    end
    if (portSel !== eSel) begin
      errors++;
      $display("FAIL %s portSel actual=%b expected=%b", tag, portSel, eSel);
    end
    if (hostData !== eDat) begin
      errors++;
      $display("FAIL %s hostData actual=%h expected=%h", tag, hostData, eDat);
    end
  endtask

  initial begin
    portData = {4'hF, 4'h6, 4'hC, 4'h3, 4'h9};
    repeat (3) @(negedge clk);
    checkPort("R1 in reset", 0, 1'b1);
    rstN = 1'b1;
    settle();
    checkPort("R1 idle after reset", 0, 1'b1);

    // R2: clear rises
    hostClr = 1'b1; settle();
    checkPort("R2 clear rise", 1, 1'b1);

    // R3: select toggles while clear is held
    hostSel = 1'b0; settle();
    checkPort("R3 held sel low", 1, 1'b0);
    hostSel = 1'b1; settle();
    checkPort("R3 held sel high", 1, 1'b1);
    hostSel = 1'b0; settle();
    hostSel = 1'b1; settle();
    checkPort("R3 held second toggle", 1, 1'b1);

    hostClr = 1'b0; settle();
    checkPort("R5 clear dropped", 1, 1'b1);

    // R4 / R5 / R6 / R7: twelve counted edges
    for (int i = 0; i < 12; i++) begin
      hostSel = VECS[i].sel;
      settle();
      checkPort($sformatf("%s edge %0d", (VECS[i].port == 0) ? "R7" : "R4",
                          i + 1), int'(VECS[i].port), VECS[i].sel);
    end

    // R7: data changes have no effect while deselected
    portData = '1; settle();
    checkPort("R7 data ignored", 0, hostSel);
    portData = {4'hF, 4'h6, 4'hC, 4'h3, 4'h9};

    // R8: restart from terminal state
    hostClr = 1'b1; settle();
    checkPort("R8 restart from end", 1, hostSel);
    hostClr = 1'b0; settle();
    for (int i = 0; i < 5; i++) begin
      hostSel = ~hostSel; settle();
    end
    checkPort("R4 fifth edge after restart", 3, hostSel);

    // R6: live data on active port 3
    portData[11:8] = 4'h5; settle();
    checkPort("R6 live nibble port 3", 3, hostSel);

    // R8: restart mid walk with select low
    hostClr = 1'b1; settle();
    checkPort("R8 restart mid walk", 1, hostSel);
    hostClr = 1'b0; settle();
    hostSel = ~hostSel; settle();
    checkPort("R4 first edge after mid restart", 1, hostSel);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog for all requirements: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule